// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts the targets of subroutine returns once instructions have been decoded. Each decoded instruction arrives with its kind, destination and source register numbers and its program counter. A jump-and-link that writes the dedicated link register is a call. For a call, the block stores the address of the instruction that follows it. A jump-register that reads the link register, and is not itself a call, is a return. For a return, the block offers the most recently stored address as the predicted target and discards that entry. Every other indirect jump passes through without a prediction.

Storage is a small circular stack, three entries deep by default. When a push finds the stack full, the oldest address is overwritten. A resolve input reports the real target of the most recent predicted return. Two counters record how many predictions have been resolved and how many of them were correct.

Top module: `ret_addr_predictor`

## Requirements
- R1: After reset, `pred_valid` is 0, both counters are 0 and the stack is empty.
- R2: A decoded instruction whose kind is JAL (code 1) or JALR (code 2) and whose `dec_rd` equals the link register (default 1) is a call. It pushes `dec_pc + INSN_BYTES` (default 4) and gives no prediction.
- R3: A decoded JALR whose `dec_rs1` is the link register and which is not a call is a return. One cycle later, when the stack holds something, `pred_valid` is 1 and `pred_target` is the most recently pushed address, which is then removed.
- R4: A JALR whose source register is not the link register gives no prediction and leaves the stack as it was.
- R5: A JAL whose destination is register 0 is a plain jump. It does not push.
- R6: A push onto a full stack overwrites the oldest entry. After four calls with depth 3, three returns yield the last three return addresses, newest first, and a fourth return yields no prediction.
- R7: A return that finds the stack empty gives `pred_valid` 0.
- R8: A `res_valid` pulse that arrives while a prediction is waiting to be resolved adds 1 to `lookup_count`. It adds 1 to `hit_count` only if `res_target` equals the predicted target. A pulse that arrives when no prediction is waiting changes neither counter.
- R9: While `dec_valid` is 0 there is no prediction and the stack does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | A decoded instruction is present |
| dec_kind | input | 2 | 0 other, 1 JAL, 2 JALR, 3 other |
| dec_rd | input | REG_W | Destination register number |
| dec_rs1 | input | REG_W | Source register number of a jump-register |
| dec_pc | input | PC_W | Address of the decoded instruction |
| pred_valid | output | 1 | Return prediction is valid (one cycle after decode) |
| pred_target | output | PC_W | Predicted return target |
| res_valid | input | 1 | The real target of the most recent prediction is known |
| res_target | input | PC_W | The real target |
| lookup_count | output | CNT_W | Number of resolved predictions |
| hit_count | output | CNT_W | Number of resolved predictions that were correct |

## Verification
The bench uses the default parameters: depth 3, link register 1, 4-byte instructions and 16-bit saturating counters. With only three entries, the fourth call already makes the stack wrap, so four calls are enough to observe the overwrite of the oldest entry and the empty-stack return that follows. The counters never come near saturation at these settings. The bench's checks cover only their increments, while the checker module verifies that hits never exceed lookups.

// File: rtl/rap_pkg.sv
package rap_pkg;
   typedef enum logic [1:0] {
      KIND_OTHER = 2'd0,
      KIND_JAL   = 2'd1,
      KIND_JALR  = 2'd2,
      KIND_RSVD  = 2'd3
   } insn_kind_e;
endpackage

// File: rtl/rap_classify.sv
module rap_classify
   import rap_pkg::*;
#(
   parameter int REG_W         = 5,
   parameter int LINK_REG      = 1,
   parameter bit CALL_VIA_JALR = 1'b1
) (
   input  logic             valid,
   input  logic [1:0]       kind,
   input  logic [REG_W-1:0] rd,
   input  logic [REG_W-1:0] rs1,
   output logic             is_call,
   output logic             is_ret
);
   localparam logic [REG_W-1:0] LINK = REG_W'(LINK_REG);

   insn_kind_e k;
   logic       link_dst;
   logic       link_src;
   logic       call_kind;

   always_comb begin
      k        = insn_kind_e'(kind);
      link_dst = (rd == LINK);
      link_src = (rs1 == LINK);
   end

   // Variant: whether an indirect jump-and-link to the link register is a call
   generate
      if (CALL_VIA_JALR) begin : g_call_both
         assign call_kind = (k == KIND_JAL) || (k == KIND_JALR);
      end else begin : g_call_direct
         assign call_kind = (k == KIND_JAL);
      end
   endgenerate

   always_comb begin
      is_call = valid && call_kind && link_dst;
      is_ret  = valid && (k == KIND_JALR) && link_src && !is_call;
   end
endmodule

// File: rtl/rap_stack.sv
module rap_stack #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [ADDR_W-1:0] push_addr,
   output logic              top_valid,
   output logic [ADDR_W-1:0] top_addr
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int FIL_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
   localparam logic [FIL_W-1:0] FULL = FIL_W'(DEPTH);

   logic [ADDR_W-1:0] slot_q [DEPTH];
   logic [PTR_W-1:0]  top_q;
   logic [PTR_W-1:0]  top_up;
   logic [PTR_W-1:0]  top_dn;
   logic [FIL_W-1:0]  fill_q;

   always_comb begin
      top_up = (top_q == LAST) ? '0 : top_q + PTR_W'(1);
      top_dn = (top_q == '0) ? LAST : top_q - PTR_W'(1);
   end

   // one write-enabled register per slot; the wrapped pointer overwrites the oldest
   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n)
               slot_q[i] <= '0;
            else if (push && (top_up == PTR_W'(i)))
               slot_q[i] <= push_addr;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         top_q  <= LAST;
         fill_q <= '0;
      end else if (push) begin
         top_q  <= top_up;
         fill_q <= (fill_q == FULL) ? fill_q : fill_q + FIL_W'(1);
      end else if (pop && (fill_q != '0)) begin
         top_q  <= top_dn;
         fill_q <= fill_q - FIL_W'(1);
      end
   end

   always_comb begin
      top_valid = (fill_q != '0);
      top_addr  = slot_q[top_q];
   end
endmodule

// File: rtl/rap_score.sv
module rap_score #(
   parameter int ADDR_W   = 32,
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pred_valid,
   input  logic [ADDR_W-1:0] pred_target,
   input  logic              res_valid,
   input  logic [ADDR_W-1:0] res_target,
   output logic [CNT_W-1:0]  lookup_count,
   output logic [CNT_W-1:0]  hit_count
);
   logic              pend_v;
   logic [ADDR_W-1:0] pend_t;
   logic              lk_inc;
   logic              hit_inc;
   logic [CNT_W-1:0]  lk_next;
   logic [CNT_W-1:0]  hit_next;

   always_comb begin
      lk_inc  = res_valid && pend_v;
      hit_inc = lk_inc && (res_target == pend_t);
   end

   generate
      if (SATURATE) begin : g_sat
         assign lk_next  = (lookup_count == '1) ? lookup_count : lookup_count + CNT_W'(1);
         assign hit_next = (hit_count == '1) ? hit_count : hit_count + CNT_W'(1);
      end else begin : g_wrap
         assign lk_next  = lookup_count + CNT_W'(1);
         assign hit_next = hit_count + CNT_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v       <= 1'b0;
         pend_t       <= '0;
         lookup_count <= '0;
         hit_count    <= '0;
      end else begin
         if (lk_inc)  lookup_count <= lk_next;
         if (hit_inc) hit_count    <= hit_next;
         if (pred_valid) begin
            pend_v <= 1'b1;
            pend_t <= pred_target;
         end else if (res_valid) begin
            pend_v <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ret_addr_predictor.sv
module ret_addr_predictor #(
   parameter int PC_W          = 32,
   parameter int DEPTH         = 3,
   parameter int REG_W         = 5,
   parameter int LINK_REG      = 1,
   parameter int INSN_BYTES    = 4,
   parameter int CNT_W         = 16,
   parameter bit CALL_VIA_JALR = 1'b1,
   parameter bit SATURATE      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_valid,
   input  logic [1:0]       dec_kind,
   input  logic [REG_W-1:0] dec_rd,
   input  logic [REG_W-1:0] dec_rs1,
   input  logic [PC_W-1:0]  dec_pc,
   output logic             pred_valid,
   output logic [PC_W-1:0]  pred_target,
   input  logic             res_valid,
   input  logic [PC_W-1:0]  res_target,
   output logic [CNT_W-1:0] lookup_count,
   output logic [CNT_W-1:0] hit_count
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (PC_W < 8) begin : g_bad_pc
         $error("PC_W must be at least 8");
      end
      if (LINK_REG <= 0 || LINK_REG >= (1 << REG_W)) begin : g_bad_link
         $error("LINK_REG must be a nonzero register number");
      end
      if (INSN_BYTES <= 0 || (INSN_BYTES & (INSN_BYTES - 1)) != 0) begin : g_bad_step
         $error("INSN_BYTES must be a power of two");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
   endgenerate

   logic            is_call;
   logic            is_ret;
   logic            top_valid;
   logic [PC_W-1:0] top_addr;
   logic [PC_W-1:0] link_addr;

   rap_classify #(
      .REG_W(REG_W), .LINK_REG(LINK_REG), .CALL_VIA_JALR(CALL_VIA_JALR)
   ) u_cls (
      .valid(dec_valid), .kind(dec_kind), .rd(dec_rd), .rs1(dec_rs1),
      .is_call(is_call), .is_ret(is_ret)
   );

   assign link_addr = dec_pc + PC_W'(INSN_BYTES);

   rap_stack #(.ADDR_W(PC_W), .DEPTH(DEPTH)) u_stk (
      .clk(clk), .rst_n(rst_n),
      .push(is_call), .pop(is_ret), .push_addr(link_addr),
      .top_valid(top_valid), .top_addr(top_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pred_valid  <= 1'b0;
         pred_target <= '0;
      end else begin
         pred_valid  <= is_ret && top_valid;
         pred_target <= top_addr;
      end
   end

   rap_score #(.ADDR_W(PC_W), .CNT_W(CNT_W), .SATURATE(SATURATE)) u_scr (
      .clk(clk), .rst_n(rst_n),
      .pred_valid(pred_valid), .pred_target(pred_target),
      .res_valid(res_valid), .res_target(res_target),
      .lookup_count(lookup_count), .hit_count(hit_count)
   );
endmodule

// File: rtl/rap_checker.sv
module rap_checker #(
   parameter int REG_W    = 5,
   parameter int LINK_REG = 1,
   parameter int CNT_W    = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dec_valid,
   input logic [1:0]       dec_kind,
   input logic [REG_W-1:0] dec_rd,
   input logic [REG_W-1:0] dec_rs1,
   input logic             pred_valid,
   input logic             res_valid,
   input logic [CNT_W-1:0] lookup_count,
   input logic [CNT_W-1:0] hit_count
);
   localparam logic [REG_W-1:0] LINK = REG_W'(LINK_REG);

   p_call_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_kind == 2'd1 && dec_rd == LINK) |=> !pred_valid);

   p_pred_from_ret_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pred_valid |-> $past(dec_valid && dec_kind == 2'd2 && dec_rs1 == LINK));

   p_other_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_kind == 2'd2 && dec_rs1 != LINK) |=> !pred_valid);

   p_hits_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hit_count <= lookup_count);

   p_lookup_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |=> $stable(lookup_count));

   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |=> !pred_valid);
endmodule

bind ret_addr_predictor rap_checker #(
   .REG_W(REG_W), .LINK_REG(LINK_REG), .CNT_W(CNT_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_kind(dec_kind),
   .dec_rd(dec_rd), .dec_rs1(dec_rs1), .pred_valid(pred_valid),
   .res_valid(res_valid), .lookup_count(lookup_count), .hit_count(hit_count)
);

// File: tb/test_ret_addr_predictor.sv
`timescale 1ns/1ps
module test_ret_addr_predictor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dec_valid = 1'b0;
   logic [1:0]  dec_kind = 2'd0;
   logic [4:0]  dec_rd = 5'd0;
   logic [4:0]  dec_rs1 = 5'd0;
   logic [31:0] dec_pc = 32'd0;
   logic        pred_valid;
   logic [31:0] pred_target;
   logic        res_valid = 1'b0;
   logic [31:0] res_target = 32'd0;
   logic [15:0] lookup_count;
   logic [15:0] hit_count;

   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ret_addr_predictor i_ret_addr_predictor (
      .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_kind(dec_kind),
      .dec_rd(dec_rd), .dec_rs1(dec_rs1), .dec_pc(dec_pc),
      .pred_valid(pred_valid), .pred_target(pred_target),
      .res_valid(res_valid), .res_target(res_target),
      .lookup_count(lookup_count), .hit_count(hit_count)
   );

   // scoreboard queues filled by the driver, drained by the monitor
   bit          exp_v_q[$];
   logic [31:0] exp_t_q[$];
   string       exp_r_q[$];

   // bench-side model of a 3-entry circular return stack
   logic [31:0] mstk [3];
   int          mptr = 2;
   int          mcnt = 0;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic issue(logic [1:0] kind, logic [4:0] rd, logic [4:0] rs1,
                        logic [31:0] pc, string req);
      bit call_i;
      bit ret_i;
      call_i = (kind == 2'd1 || kind == 2'd2) && rd == 5'd1;
      ret_i  = !call_i && kind == 2'd2 && rs1 == 5'd1;
      if (call_i) begin
         mptr = (mptr + 1) % 3;
         mstk[mptr] = pc + 32'd4;
         if (mcnt < 3) mcnt++;
         exp_v_q.push_back(1'b0); exp_t_q.push_back(32'd0);
      end else if (ret_i && mcnt > 0) begin
         exp_v_q.push_back(1'b1); exp_t_q.push_back(mstk[mptr]);
         mptr = (mptr + 2) % 3;
         mcnt--;
      end else begin
         exp_v_q.push_back(1'b0); exp_t_q.push_back(32'd0);
      end
      exp_r_q.push_back(req);
      dec_valid = 1'b1; dec_kind = kind; dec_rd = rd; dec_rs1 = rs1; dec_pc = pc;
      tick();
      dec_valid = 1'b0;
   endtask

   logic mon_armed = 1'b0;
   always @(posedge clk) mon_armed <= rst_n && dec_valid;

   always @(negedge clk) begin
      if (mon_armed && exp_v_q.size() > 0) begin
         bit          ev;
         logic [31:0] et;
         string       er;
         ev = exp_v_q.pop_front();
         et = exp_t_q.pop_front();
         er = exp_r_q.pop_front();
         check(er, {31'd0, pred_valid}, {31'd0, ev});
         if (ev) check(er, pred_target, et);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", {31'd0, pred_valid}, 32'd0);
      check("R1", {16'd0, lookup_count}, 32'd0);
      check("R1", {16'd0, hit_count}, 32'd0);
      rst_n = 1'b1;
      tick();
      issue(2'd2, 5'd0, 5'd1, 32'h0000_0040, "R1");    // empty after reset

      // R2 / R3: call then return
      issue(2'd1, 5'd1, 5'd0, 32'h0000_0100, "R2");
      issue(2'd2, 5'd0, 5'd1, 32'h0000_0800, "R3");
      // R7: return on empty stack
      issue(2'd2, 5'd0, 5'd1, 32'h0000_0804, "R7");

      // R5: plain JAL to x0 must not push
      issue(2'd1, 5'd0, 5'd0, 32'h0000_0200, "R5");
      issue(2'd2, 5'd0, 5'd1, 32'h0000_0900, "R5");

      // R4: jump through another register, stack left intact
      issue(2'd1, 5'd1, 5'd0, 32'h0000_0300, "R2");
      issue(2'd2, 5'd0, 5'd5, 32'h0000_0a00, "R4");
      issue(2'd2, 5'd0, 5'd1, 32'h0000_0a04, "R4");

      // R9: call-like fields with dec_valid low
      issue(2'd1, 5'd1, 5'd0, 32'h0000_0400, "R2");
      dec_kind = 2'd1; dec_rd = 5'd1; dec_pc = 32'h0000_7000;
      tick();
      check("R9", {31'd0, pred_valid}, 32'd0);
      dec_kind = 2'd2; dec_rd = 5'd0; dec_rs1 = 5'd1;
      tick();
      check("R9", {31'd0, pred_valid}, 32'd0);
      issue(2'd2, 5'd0, 5'd1, 32'h0000_0b00, "R9");
      issue(2'd2, 5'd0, 5'd1, 32'h0000_0b04, "R9");

      // R2: indirect call (JALR writing the link register) pushes
      issue(2'd2, 5'd1, 5'd7, 32'h0000_0500, "R2");
      issue(2'd2, 5'd0, 5'd1, 32'h0000_0c00, "R2");

      // R6: overflow wraps, oldest lost
      issue(2'd1, 5'd1, 5'd0, 32'h0000_1000, "R6");
      issue(2'd1, 5'd1, 5'd0, 32'h0000_2000, "R6");
      issue(2'd1, 5'd1, 5'd0, 32'h0000_3000, "R6");
      issue(2'd1, 5'd1, 5'd0, 32'h0000_4000, "R6");
      issue(2'd2, 5'd0, 5'd1, 32'h0000_d000, "R6");
      issue(2'd2, 5'd0, 5'd1, 32'h0000_d004, "R6");
      issue(2'd2, 5'd0, 5'd1, 32'h0000_d008, "R6");
      issue(2'd2, 5'd0, 5'd1, 32'h0000_d00c, "R6");

      // R8: lookup and hit counting
      check("R8", {16'd0, lookup_count}, 32'd0);
      issue(2'd1, 5'd1, 5'd0, 32'h0000_5000, "R8");
      issue(2'd2, 5'd0, 5'd1, 32'h0000_e000, "R8");
      tick();
      res_valid = 1'b1; res_target = 32'h0000_5004;
      tick();
      res_valid = 1'b0;
      check("R8", {16'd0, lookup_count}, 32'd1);
      check("R8", {16'd0, hit_count}, 32'd1);
      res_valid = 1'b1; res_target = 32'h0000_5004;
      tick();
      res_valid = 1'b0;
      check("R8", {16'd0, lookup_count}, 32'd1);
      check("R8", {16'd0, hit_count}, 32'd1);
      issue(2'd1, 5'd1, 5'd0, 32'h0000_6000, "R8");
      issue(2'd2, 5'd0, 5'd1, 32'h0000_e100, "R8");
      tick();
      res_valid = 1'b1; res_target = 32'h0000_dead;
      tick();
      res_valid = 1'b0;
      check("R8", {16'd0, lookup_count}, 32'd2);
      check("R8", {16'd0, hit_count}, 32'd1);

      tick();
      check("R3", exp_v_q.size(), 32'd0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule